// File: doc/BRIEF.md
# Fully Associative Word Cache Controller

This block sits between a word-addressed requester and a slow main memory. It keeps sixteen lines of eight words each. Any memory block may be placed in any line, and a lookup compares the request tag against every stored tag at the same time. Each line carries a valid bit, a dirty bit and a tag.

A lookup that finds its block reads or writes the line and finishes at once. A lookup that misses first claims a line. The lowest-numbered empty line is taken if one exists; otherwise the least recently used line is replaced. If the line being replaced holds modified data, that data is first written back as eight words. Next, all eight words of the new block are fetched, one handshake per word. Only after the whole block is in place is the request repeated inside the cache, so the requester never receives a word while the fill is still running. Writes that miss allocate the block in the same way, and the write is then merged into the line.

Two counters are exposed: one counts requests and one counts misses. The internal repeat of a request after a fill adds nothing to either counter.

Top module: `fa_cache_ctrl`

## Requirements
- R1: A read whose block is resident returns the stored word with `cpu_hit`=1 and causes no memory traffic.
- R2: The address is split into a tag in bits [15:3] and a word offset in bits [2:0]. A request hits when a valid line holds its tag, whichever line that is.
- R3: After reset all lines are invalid. `cpu_ready`=1, both counters are 0 and `mem_req`=0, and the first request of any kind misses.
- R4: On a miss, eight reads are issued at offsets 0 to 7 in ascending order with the request tag. Only after these reads is `cpu_done` raised, and it comes with the requested word and `cpu_hit`=0.
- R5: While any line is invalid, a miss fills an empty line. Sixteen distinct blocks therefore become resident with no write-back, and all sixteen then hit.
- R6: When every line is valid, a miss replaces the least recently used line, where both hits and fills count as uses.
- R7: A write hit stores the word, marks the line dirty and causes no memory traffic. A later read returns the new word.
- R8: Before a dirty victim is replaced, its eight words are written at offsets 0 to 7 in ascending order under the victim's tag, and only then do the fill reads begin. A clean victim causes no writes.
- R9: Each request adds exactly 1 to `ref_count`. `miss_count` grows by 1 for each request that misses, and the internal repeat after a fill is not counted.
- R10: A write miss fetches the block, then merges the written word into the line. Later reads hit and return the merged word and the fetched neighbours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request strobe, accepted while `cpu_ready`=1 |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Word address |
| cpu_wdata | input | 16 | Write data |
| cpu_ready | output | 1 | Controller idle, can take a request |
| cpu_done | output | 1 | One-cycle pulse when a request completes |
| cpu_hit | output | 1 | With `cpu_done`: 1 if the request hit on its first lookup |
| cpu_rdata | output | 16 | Read data, valid with `cpu_done` |
| mem_req | output | 1 | Memory word transfer pending |
| mem_we | output | 1 | 1 = write-back word, 0 = fill read |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Write-back data |
| mem_ack | input | 1 | One-cycle acknowledge of the current word |
| mem_rdata | input | 16 | Fill data, valid with `mem_ack` |
| ref_count | output | 32 | Requests served |
| miss_count | output | 32 | Requests that missed |

## Verification
The bench builds the controller with its default parameters: 16 lines, 8-word blocks, 16-bit words and addresses, and 32-bit counters. Its memory model answers each word after 3 cycles, so one miss with a write-back lasts only about a hundred cycles. This short latency makes it cheap to fill all sixteen lines, to run replacement past a full cache, and to push a modified line out and read it back. Because there are only sixteen lines, the bench can drive the recency order exactly with a short loop of touches. It can then pick which line becomes the victim, clean or dirty.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_LOOKUP = 2'd1,
      ST_WBACK  = 2'd2,
      ST_FILL   = 2'd3
   } fa_state_e;

endpackage

// File: rtl/fa_tag_match.sv
module fa_tag_match #(
   parameter int LINES = 16,
   parameter int TAG_W = 13,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic [LINES-1:0]            valid_i,
   input  logic [LINES-1:0][TAG_W-1:0] tags_i,
   input  logic [TAG_W-1:0]            look_tag_i,
   output logic [LINES-1:0]            match_o,
   output logic                        hit_o,
   output logic [IDX_W-1:0]            hit_idx_o
);

   for (genvar g = 0; g < LINES; g++) begin : g_cmp
      assign match_o[g] = valid_i[g] && (tags_i[g] == look_tag_i);
   end

   // exactly one match counts as a hit
   assign hit_o = (match_o != '0) && ((match_o & (match_o - 1'b1)) == '0);

   // OR-based encoder, no priority chain
   always_comb begin
      hit_idx_o = '0;
      for (int i = 0; i < LINES; i++) begin
         if (match_o[i]) hit_idx_o = hit_idx_o | IDX_W'(i);
      end
   end

endmodule

// File: rtl/fa_lru.sv
module fa_lru #(
   parameter int LINES = 16,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] valid_i,
   input  logic             touch_i,
   input  logic [IDX_W-1:0] touch_idx_i,
   output logic [IDX_W-1:0] pick_idx_o
);

   localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(LINES - 1);

   // ages form a permutation of 0..LINES-1; 0 = most recent
   logic [IDX_W-1:0] age_q [LINES];
   logic [IDX_W-1:0] free_idx;
   logic [IDX_W-1:0] old_idx;
   logic             any_free;

   for (genvar g = 0; g < LINES; g++) begin : g_age
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            age_q[g] <= IDX_W'(g);
         end else if (touch_i) begin
            if (IDX_W'(g) == touch_idx_i)
               age_q[g] <= '0;
            else if (age_q[g] < age_q[touch_idx_i])
               age_q[g] <= age_q[g] + IDX_W'(1);
         end
      end
   end

   always_comb begin
      free_idx = '0;
      any_free = 1'b0;
      for (int i = LINES - 1; i >= 0; i--) begin
         if (!valid_i[i]) begin
            free_idx = IDX_W'(i);
            any_free = 1'b1;
         end
      end
   end

   always_comb begin
      old_idx = '0;
      for (int i = 0; i < LINES; i++) begin
         if (age_q[i] == AGE_MAX) old_idx = old_idx | IDX_W'(i);
      end
   end

   assign pick_idx_o = any_free ? free_idx : old_idx;

endmodule

// File: rtl/fa_data_store.sv
module fa_data_store #(
   parameter int LINES  = 16,
   parameter int OFF_W  = 3,
   parameter int DATA_W = 16,
   localparam int IDX_W = $clog2(LINES),
   localparam int DEPTH = LINES << OFF_W
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [IDX_W-1:0]  wline_i,
   input  logic [OFF_W-1:0]  woff_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [IDX_W-1:0]  rline_i,
   input  logic [OFF_W-1:0]  roff_i,
   output logic [DATA_W-1:0] rdata_o
);

   logic [DATA_W-1:0] words_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) words_q[{wline_i, woff_i}] <= wdata_i;
   end

   assign rdata_o = words_q[{rline_i, roff_i}];

endmodule

// File: rtl/fa_cache_ctrl.sv
module fa_cache_ctrl
   import fa_cache_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int OFF_W  = 3,
   parameter int LINES  = 16,
   parameter int DATA_W = 16,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic              cpu_done,
   output logic              cpu_hit,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [CNT_W-1:0]  ref_count,
   output logic [CNT_W-1:0]  miss_count
);

   localparam int TAG_W = ADDR_W - OFF_W;
   localparam int IDX_W = $clog2(LINES);
   localparam logic [OFF_W-1:0] LAST_BEAT = '1;

   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (OFF_W < 1 || OFF_W >= ADDR_W) begin : g_bad_off
      $error("OFF_W must lie in 1..ADDR_W-1");
   end

   fa_state_e state_q;
   logic                        req_we_q;
   logic [TAG_W-1:0]            req_tag_q;
   logic [OFF_W-1:0]            req_off_q;
   logic [DATA_W-1:0]           req_wdata_q;
   logic                        retry_q;
   logic [IDX_W-1:0]            line_q;
   logic [OFF_W-1:0]            beat_q;
   logic [LINES-1:0]            valid_q;
   logic [LINES-1:0]            dirty_q;
   logic [LINES-1:0][TAG_W-1:0] tag_q;
   logic                        done_q;
   logic                        hit_q;
   logic [DATA_W-1:0]           rdata_q;
   logic [CNT_W-1:0]            ref_q;
   logic [CNT_W-1:0]            miss_q;

   logic [LINES-1:0] match_vec;
   logic             look_hit;
   logic [IDX_W-1:0] hit_idx;
   logic [IDX_W-1:0] pick_idx;
   logic             lru_touch;
   logic [IDX_W-1:0] lru_idx;
   logic             st_we;
   logic [IDX_W-1:0] st_wline;
   logic [OFF_W-1:0] st_woff;
   logic [DATA_W-1:0] st_wdata;
   logic [IDX_W-1:0] st_rline;
   logic [OFF_W-1:0] st_roff;
   logic [DATA_W-1:0] st_rdata;
   logic             fill_last;

   fa_tag_match #(.LINES(LINES), .TAG_W(TAG_W)) u_match (
      .valid_i    (valid_q),
      .tags_i     (tag_q),
      .look_tag_i (req_tag_q),
      .match_o    (match_vec),
      .hit_o      (look_hit),
      .hit_idx_o  (hit_idx)
   );

   fa_lru #(.LINES(LINES)) u_lru (
      .clk         (clk),
      .rst_n       (rst_n),
      .valid_i     (valid_q),
      .touch_i     (lru_touch),
      .touch_idx_i (lru_idx),
      .pick_idx_o  (pick_idx)
   );

   fa_data_store #(.LINES(LINES), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_store (
      .clk     (clk),
      .we_i    (st_we),
      .wline_i (st_wline),
      .woff_i  (st_woff),
      .wdata_i (st_wdata),
      .rline_i (st_rline),
      .roff_i  (st_roff),
      .rdata_o (st_rdata)
   );

   assign fill_last = (state_q == ST_FILL) && mem_ack && (beat_q == LAST_BEAT);

   // recency update on a lookup hit or on fill completion
   always_comb begin
      lru_touch = 1'b0;
      lru_idx   = hit_idx;
      if (state_q == ST_LOOKUP && look_hit) begin
         lru_touch = 1'b1;
      end else if (fill_last) begin
         lru_touch = 1'b1;
         lru_idx   = line_q;
      end
   end

   // single write port: fill beats or write hits
   always_comb begin
      st_we    = 1'b0;
      st_wline = hit_idx;
      st_woff  = req_off_q;
      st_wdata = req_wdata_q;
      if (state_q == ST_FILL && mem_ack) begin
         st_we    = 1'b1;
         st_wline = line_q;
         st_woff  = beat_q;
         st_wdata = mem_rdata;
      end else if (state_q == ST_LOOKUP && look_hit && req_we_q) begin
         st_we = 1'b1;
      end
   end

   assign st_rline = (state_q == ST_WBACK) ? line_q : hit_idx;
   assign st_roff  = (state_q == ST_WBACK) ? beat_q : req_off_q;

   assign mem_req   = (state_q == ST_WBACK) || (state_q == ST_FILL);
   assign mem_we    = (state_q == ST_WBACK);
   assign mem_addr  = (state_q == ST_WBACK) ? {tag_q[line_q], beat_q} : {req_tag_q, beat_q};
   assign mem_wdata = st_rdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         req_we_q    <= 1'b0;
         req_tag_q   <= '0;
         req_off_q   <= '0;
         req_wdata_q <= '0;
         retry_q     <= 1'b0;
         line_q      <= '0;
         beat_q      <= '0;
         valid_q     <= '0;
         dirty_q     <= '0;
         tag_q       <= '0;
         done_q      <= 1'b0;
         hit_q       <= 1'b0;
         rdata_q     <= '0;
         ref_q       <= '0;
         miss_q      <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (cpu_req) begin
                  req_we_q    <= cpu_we;
                  req_tag_q   <= cpu_addr[ADDR_W-1:OFF_W];
                  req_off_q   <= cpu_addr[OFF_W-1:0];
                  req_wdata_q <= cpu_wdata;
                  state_q     <= ST_LOOKUP;
               end
            end
            ST_LOOKUP: begin
               if (look_hit) begin
                  if (req_we_q) begin
                     dirty_q[hit_idx] <= 1'b1;
                     rdata_q          <= req_wdata_q;
                  end else begin
                     rdata_q <= st_rdata;
                  end
                  if (!retry_q) ref_q <= ref_q + CNT_W'(1);
                  hit_q   <= !retry_q;
                  done_q  <= 1'b1;
                  retry_q <= 1'b0;
                  state_q <= ST_IDLE;
               end else begin
                  ref_q  <= ref_q + CNT_W'(1);
                  miss_q <= miss_q + CNT_W'(1);
                  line_q <= pick_idx;
                  beat_q <= '0;
                  if (valid_q[pick_idx] && dirty_q[pick_idx])
                     state_q <= ST_WBACK;
                  else
                     state_q <= ST_FILL;
               end
            end
            ST_WBACK: begin
               if (mem_ack) begin
                  beat_q <= beat_q + OFF_W'(1);
                  if (beat_q == LAST_BEAT) state_q <= ST_FILL;
               end
            end
            ST_FILL: begin
               if (mem_ack) begin
                  beat_q <= beat_q + OFF_W'(1);
                  if (beat_q == LAST_BEAT) begin
                     valid_q[line_q] <= 1'b1;
                     dirty_q[line_q] <= 1'b0;
                     tag_q[line_q]   <= req_tag_q;
                     retry_q         <= 1'b1;
                     state_q         <= ST_LOOKUP;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cpu_ready  = (state_q == ST_IDLE);
   assign cpu_done   = done_q;
   assign cpu_hit    = hit_q;
   assign cpu_rdata  = rdata_q;
   assign ref_count  = ref_q;
   assign miss_count = miss_q;

endmodule

// File: rtl/fa_cache_chk.sv
module fa_cache_chk #(
   parameter int LINES = 16,
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LINES-1:0] valid_vec,
   input logic [LINES-1:0] match_vec,
   input logic             cpu_ready,
   input logic             cpu_done,
   input logic             mem_req,
   input logic             mem_ack,
   input logic [CNT_W-1:0] ref_count,
   input logic [CNT_W-1:0] miss_count
);

   p_one_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_vec));

   p_empty_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (valid_vec == '0));

   p_no_forward_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ack |=> !cpu_done);

   p_valid_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(valid_vec) & ~valid_vec) == '0));

   p_idle_bus_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> !mem_req);

   p_ref_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_count == $past(ref_count)) || (ref_count == $past(ref_count) + CNT_W'(1)));

   p_miss_with_ref_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_count != $past(miss_count)) |-> (ref_count != $past(ref_count)));

endmodule

bind fa_cache_ctrl fa_cache_chk #(.LINES(LINES), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .valid_vec  (valid_q),
   .match_vec  (match_vec),
   .cpu_ready  (cpu_ready),
   .cpu_done   (cpu_done),
   .mem_req    (mem_req),
   .mem_ack    (mem_ack),
   .ref_count  (ref_count),
   .miss_count (miss_count)
);

// File: tb/tb_fa_cache_ctrl.sv
`timescale 1ns/1ps
module tb_fa_cache_ctrl;

   localparam int MEM_LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0;
   logic        cpu_we = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [15:0] cpu_wdata = '0;
   logic        cpu_ready, cpu_done, cpu_hit;
   logic [15:0] cpu_rdata;
   logic        mem_req, mem_we;
   logic [15:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [15:0] mem_rdata = '0;
   logic [31:0] ref_count, miss_count;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   fa_cache_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .ref_count(ref_count), .miss_count(miss_count)
   );

   // ---------------- memory model ----------------
   logic [15:0] wr_mem [int];
   logic [15:0] lg_addr [$];
   logic        lg_we [$];
   logic [15:0] lg_data [$];
   int          wcnt = 0;

   function automatic logic [15:0] pat(input logic [15:0] a);
      logic [15:0] p;
      p = a * 16'h9E37;
      return p ^ 16'h5A5A;
   endfunction

   function automatic logic [15:0] mem_val(input logic [15:0] a);
      if (wr_mem.exists(int'(a))) return wr_mem[int'(a)];
      return pat(a);
   endfunction

   function automatic logic [15:0] ba(input logic [12:0] tag, input logic [2:0] off);
      return {tag, off};
   endfunction

   always @(posedge clk) begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
         if (wcnt == MEM_LAT - 1) begin
            wcnt <= 0;
            mem_ack <= 1'b1;
            lg_addr.push_back(mem_addr);
            lg_we.push_back(mem_we);
            lg_data.push_back(mem_wdata);
            if (mem_we) wr_mem[int'(mem_addr)] = mem_wdata;
            else mem_rdata <= mem_val(mem_addr);
         end else begin
            wcnt <= wcnt + 1;
         end
      end else begin
         wcnt <= 0;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic clear_log();
      lg_addr.delete();
      lg_we.delete();
      lg_data.delete();
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cpu_req = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      clear_log();
   endtask

   task automatic access(input logic we, input logic [15:0] a, input logic [15:0] wd,
                         output logic [15:0] rd, output logic h);
      @(negedge clk);
      while (!cpu_ready) @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
      @(negedge clk);
      cpu_req = 1'b0;
      while (!cpu_done) @(negedge clk);
      rd = cpu_rdata;
      h  = cpu_hit;
   endtask

   function automatic int count_writes();
      int n = 0;
      foreach (lg_we[i]) if (lg_we[i]) n++;
      return n;
   endfunction

   task automatic check_reads(input string req, input logic [12:0] tag, input int start);
      for (int k = 0; k < 8; k++) begin
         chk(req, "fill beat is read", 32'(lg_we[start + k]), 32'd0);
         chk(req, "fill beat address", 32'(lg_addr[start + k]), 32'(ba(tag, 3'(k))));
      end
   endtask

   task automatic fill_blocks(input logic [12:0] base);
      logic [15:0] rd; logic h;
      for (int i = 0; i < 16; i++) access(1'b0, ba(base + 13'(i), 3'd0), 16'h0, rd, h);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset_first_miss();
      logic [15:0] rd; logic h;
      do_reset();
      chk("R3", "ready after reset", 32'(cpu_ready), 32'd1);
      chk("R3", "ref_count after reset", ref_count, 32'd0);
      chk("R3", "miss_count after reset", miss_count, 32'd0);
      chk("R3", "mem_req after reset", 32'(mem_req), 32'd0);
      access(1'b0, ba(13'd2, 3'd5), 16'h0, rd, h);
      chk("R3", "first access misses", 32'(h), 32'd0);
      chk("R4", "word after fill", 32'(rd), 32'(pat(ba(13'd2, 3'd5))));
      chk("R4", "fill length", 32'(lg_addr.size()), 32'd8);
      if (lg_addr.size() == 8) check_reads("R4", 13'd2, 0);
      chk("R9", "ref after one miss", ref_count, 32'd1);
      chk("R9", "miss after one miss", miss_count, 32'd1);
   endtask

   task automatic t_hit_same_block();
      logic [15:0] rd; logic h;
      clear_log();
      access(1'b0, ba(13'd2, 3'd0), 16'h0, rd, h);
      chk("R1", "hit flag offset 0", 32'(h), 32'd1);
      chk("R1", "hit data offset 0", 32'(rd), 32'(pat(ba(13'd2, 3'd0))));
      access(1'b0, ba(13'd2, 3'd7), 16'h0, rd, h);
      chk("R2", "hit flag offset 7", 32'(h), 32'd1);
      chk("R2", "hit data offset 7", 32'(rd), 32'(pat(ba(13'd2, 3'd7))));
      chk("R1", "no memory traffic on hits", 32'(lg_addr.size()), 32'd0);
      chk("R9", "ref after hits", ref_count, 32'd3);
      chk("R9", "miss after hits", miss_count, 32'd1);
   endtask

   task automatic t_free_fill();
      logic [15:0] rd; logic h;
      int miss_n = 0, hit_n = 0, bad = 0;
      clear_log();
      for (int i = 1; i < 16; i++) begin
         access(1'b0, ba(13'h100 + 13'(i), 3'(i)), 16'h0, rd, h);
         if (!h) miss_n++;
         if (rd !== pat(ba(13'h100 + 13'(i), 3'(i)))) bad++;
      end
      chk("R5", "misses while filling", 32'(miss_n), 32'd15);
      chk("R5", "fill data mismatches", 32'(bad), 32'd0);
      chk("R5", "no write-back into empty lines", 32'(count_writes()), 32'd0);
      access(1'b0, ba(13'd2, 3'd1), 16'h0, rd, h);
      if (h) hit_n++;
      for (int i = 1; i < 16; i++) begin
         access(1'b0, ba(13'h100 + 13'(i), 3'd6), 16'h0, rd, h);
         if (h) hit_n++;
      end
      chk("R2", "all sixteen blocks resident", 32'(hit_n), 32'd16);
      chk("R9", "miss count after fill", miss_count, 32'd16);
   endtask

   task automatic t_write_hit();
      logic [15:0] rd; logic h;
      clear_log();
      access(1'b1, ba(13'h105, 3'd3), 16'hBEEF, rd, h);
      chk("R7", "write hit flag", 32'(h), 32'd1);
      chk("R7", "write hit no traffic", 32'(lg_addr.size()), 32'd0);
      access(1'b0, ba(13'h105, 3'd3), 16'h0, rd, h);
      chk("R7", "read back written word", 32'(rd), 32'hBEEF);
   endtask

   task automatic t_lru();
      logic [15:0] rd; logic h;
      logic [31:0] r0, m0;
      do_reset();
      fill_blocks(13'h500);
      access(1'b0, ba(13'h500, 3'd2), 16'h0, rd, h);
      chk("R6", "touch oldest block", 32'(h), 32'd1);
      clear_log();
      r0 = ref_count; m0 = miss_count;
      access(1'b0, ba(13'h600, 3'd4), 16'h0, rd, h);
      chk("R6", "new block misses", 32'(h), 32'd0);
      chk("R8", "clean victim no writes", 32'(count_writes()), 32'd0);
      access(1'b0, ba(13'h500, 3'd2), 16'h0, rd, h);
      chk("R6", "recently touched block kept", 32'(h), 32'd1);
      access(1'b0, ba(13'h501, 3'd0), 16'h0, rd, h);
      chk("R6", "least recent block evicted", 32'(h), 32'd0);
      access(1'b0, ba(13'h503, 3'd0), 16'h0, rd, h);
      chk("R6", "next-oldest still resident", 32'(h), 32'd1);
      chk("R9", "ref delta", ref_count - r0, 32'd4);
      chk("R9", "miss delta", miss_count - m0, 32'd2);
   endtask

   task automatic t_dirty_victim();
      logic [15:0] rd; logic h;
      int bad = 0;
      do_reset();
      fill_blocks(13'h200);
      access(1'b1, ba(13'h200, 3'd5), 16'hC0DE, rd, h);
      for (int i = 1; i < 16; i++) access(1'b0, ba(13'h200 + 13'(i), 3'd0), 16'h0, rd, h);
      clear_log();
      access(1'b0, ba(13'h300, 3'd1), 16'h0, rd, h);
      chk("R8", "transfer count with write-back", 32'(lg_addr.size()), 32'd16);
      if (lg_addr.size() == 16) begin
         for (int k = 0; k < 8; k++) begin
            if (lg_we[k] !== 1'b1) bad++;
            if (lg_addr[k] !== ba(13'h200, 3'(k))) bad++;
            if (lg_data[k] !== ((k == 5) ? 16'hC0DE : pat(ba(13'h200, 3'(k))))) bad++;
         end
         chk("R8", "write-back beats before fill", 32'(bad), 32'd0);
         check_reads("R8", 13'h300, 8);
      end
      chk("R4", "data after write-back and fill", 32'(rd), 32'(pat(ba(13'h300, 3'd1))));
      clear_log();
      access(1'b0, ba(13'h200, 3'd5), 16'h0, rd, h);
      chk("R8", "evicted block misses", 32'(h), 32'd0);
      chk("R8", "written-back word returns", 32'(rd), 32'hC0DE);
      chk("R8", "clean victim after that", 32'(count_writes()), 32'd0);
   endtask

   task automatic t_write_miss();
      logic [15:0] rd; logic h;
      logic [31:0] r0, m0;
      clear_log();
      r0 = ref_count; m0 = miss_count;
      access(1'b1, ba(13'h400, 3'd2), 16'h1234, rd, h);
      chk("R10", "write miss flag", 32'(h), 32'd0);
      chk("R10", "block fetched", 32'(lg_addr.size()), 32'd8);
      if (lg_addr.size() == 8) check_reads("R10", 13'h400, 0);
      access(1'b0, ba(13'h400, 3'd2), 16'h0, rd, h);
      chk("R10", "merged word hits", 32'(h), 32'd1);
      chk("R10", "merged word value", 32'(rd), 32'h1234);
      access(1'b0, ba(13'h400, 3'd3), 16'h0, rd, h);
      chk("R10", "neighbour word value", 32'(rd), 32'(pat(ba(13'h400, 3'd3))));
      chk("R9", "write miss ref delta", ref_count - r0, 32'd3);
      chk("R9", "write miss miss delta", miss_count - m0, 32'd1);
   endtask

   initial begin
      t_reset_first_miss();
      t_hit_same_block();
      t_free_fill();
      t_write_hit();
      t_lru();
      t_dirty_victim();
      t_write_miss();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule